// File: doc/BRIEF.md
# Sampled Integer PID Heater Controller

This block closes a temperature loop around a heater. A clock-enable pulse marks each sample instant. On that pulse the block takes a set-point and a measured temperature, both unsigned whole degrees. It forms a signed error and evaluates three terms with integer arithmetic:

- a proportional term,
- an accumulated (integral) term whose gain arrives pre-multiplied by 1024 and whose product is scaled back down by a 10-bit right shift that truncates toward zero,
- a difference (derivative) term.

The three terms are added and the sum is clamped to a heater power command between 0 and 5000 W. A one-cycle valid strobe goes with each new command, and the three terms are brought out so that the loop can be observed.

The gains are unsigned inputs, so tuning stays outside the block. Between sample pulses every output holds its value. A controller built this way is normally driven from a slow tick, such as one pulse per second, that is derived from the system clock.

Top module: `pid_heater_ctrl`

## Requirements
- R1: The error is setPoint minus measTemp as a signed value of TEMP_W+1 bits. Any unsigned TEMP_W-bit input is accepted, which covers set-points from 100 to 250 degrees.
- R2: State changes only on a clock edge where sampleEn is 1. The new powerOut and term values appear at that edge. With sampleEn at 0, all outputs hold their values even when the inputs change.
- R3: propTerm equals gainP times the current error.
- R4: On each update the accumulator adds the current error, and the sum already includes that error. intTerm equals accumulator times gainIs, divided by 1024 with truncation toward zero, so a negative product is never floored (for example, -5 gives 0).
- R5: derTerm equals gainD times (current error minus the error of the previous update). The previous error is 0 for the first update after reset.
- R6: powerOut equals propTerm + intTerm + derTerm, clamped to the inclusive range 0 to 5000.
- R7: The accumulator saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 and never wraps.
- R8: While rst_n is low, powerOut, all three terms and powerValid are 0, and the accumulator and previous error are cleared.
- R9: powerValid is 1 for exactly the one cycle that follows each update edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample pulse; one update per cycle in which it is high |
| setPoint | input | TEMP_W | Desired temperature, unsigned degrees |
| measTemp | input | TEMP_W | Measured temperature, unsigned degrees |
| gainP | input | GAIN_W | Proportional gain |
| gainIs | input | GAIN_W | Integral gain scaled by 1024 |
| gainD | input | GAIN_W | Derivative gain |
| powerOut | output | PWR_W (13) | Clamped heater power command, 0..5000 |
| powerValid | output | 1 | One-cycle strobe after each update |
| propTerm | output | TERM_W | Proportional term, signed |
| intTerm | output | TERM_W | Integral term after scaling, signed |
| derTerm | output | TERM_W | Derivative term, signed |

## Verification
Accumulator saturation and output clamping can occur in the same update. So can the toward-zero truncation of a negative integral product and the clamp of the sum at zero. A long run with the error held at its most negative value drives the accumulator into its lower limit while the summed power is pinned at 0. The bench checks every step against its own model: the accumulator must stay at the limit, intTerm must follow the truncated product, and powerOut must stay at 0. Directed small negative products then separate truncation from flooring. Random stimulus mixes updates with idle cycles and sweeps the set-points, the temperatures and the gains.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int POWER_MAX   = 5000;
  localparam int INT_SHIFT   = 10;
  localparam int PWR_W       = $clog2(POWER_MAX + 1);

  typedef struct packed {
    logic update;   // evaluate the loop this cycle
    logic publish;  // a fresh command sits on the outputs
  } pid_strobe_t;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sampleEn,
  output pid_strobe_t strobe
);
  logic publishQ;

  always_ff @(posedge clk) begin
    if (!rst_n) publishQ <= 1'b0;
    else        publishQ <= sampleEn;
  end

  always_comb begin
    strobe.update  = sampleEn & rst_n;
    strobe.publish = publishQ;
  end

  AST_VALID_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    sampleEn |=> strobe.publish);  // R9
  AST_VALID_ONLY_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleEn |=> !strobe.publish);  // R9
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int TEMP_W = 9,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 24,
  localparam int ERR_W  = TEMP_W + 1,
  localparam int TERM_W = ACC_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pid_strobe_t              strobe,
  input  logic [TEMP_W-1:0]        setPoint,
  input  logic [TEMP_W-1:0]        measTemp,
  input  logic [GAIN_W-1:0]        gainP,
  input  logic [GAIN_W-1:0]        gainIs,
  input  logic [GAIN_W-1:0]        gainD,
  output logic [PWR_W-1:0]         powerOut,
  output logic signed [TERM_W-1:0] propTerm,
  output logic signed [TERM_W-1:0] intTerm,
  output logic signed [TERM_W-1:0] derTerm
);
  localparam int SUM_W = TERM_W + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [TERM_W-1:0] ROUND_BIAS = TERM_W'((1 << INT_SHIFT) - 1);

  logic signed [ERR_W-1:0]  errVal, prevErrQ;
  logic signed [ACC_W-1:0]  accQ, accNext;
  logic signed [ACC_W:0]    accWide;
  logic signed [TERM_W-1:0] gP, gI, gD, errX, diffX, accX;
  logic signed [TERM_W-1:0] propNext, intProd, intNext, derNext;
  logic signed [SUM_W-1:0]  sumVal;
  logic [PWR_W-1:0]         powerNext;

  always_comb begin
    errVal  = $signed({1'b0, setPoint}) - $signed({1'b0, measTemp});
    accWide = (ACC_W+1)'(accQ) + (ACC_W+1)'(errVal);
    if (accWide > (ACC_W+1)'(ACC_MAX))      accNext = ACC_MAX;
    else if (accWide < (ACC_W+1)'(ACC_MIN)) accNext = ACC_MIN;
    else                                    accNext = accWide[ACC_W-1:0];

    gP    = TERM_W'($signed({1'b0, gainP}));
    gI    = TERM_W'($signed({1'b0, gainIs}));
    gD    = TERM_W'($signed({1'b0, gainD}));
    errX  = TERM_W'(errVal);
    diffX = TERM_W'(errVal) - TERM_W'(prevErrQ);
    accX  = TERM_W'(accNext);

    propNext = gP * errX;
    intProd  = accX * gI;
    if (intProd < 0) intNext = (intProd + ROUND_BIAS) >>> INT_SHIFT;
    else             intNext = intProd >>> INT_SHIFT;
    derNext  = gD * diffX;

    sumVal = SUM_W'(propNext) + SUM_W'(intNext) + SUM_W'(derNext);
    if (sumVal < 0)                      powerNext = '0;
    else if (sumVal > SUM_W'(POWER_MAX)) powerNext = PWR_W'(POWER_MAX);
    else                                 powerNext = sumVal[PWR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ     <= '0;
      prevErrQ <= '0;
      propTerm <= '0;
      intTerm  <= '0;
      derTerm  <= '0;
      powerOut <= '0;
    end else if (strobe.update) begin
      accQ     <= accNext;
      prevErrQ <= errVal;
      propTerm <= propNext;
      intTerm  <= intNext;
      derTerm  <= derNext;
      powerOut <= powerNext;
    end
  end

  AST_POWER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    powerOut <= PWR_W'(POWER_MAX));  // R6
  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.update |=> $stable(powerOut) && $stable(intTerm) && $stable(accQ));  // R2
  AST_ACC_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && accQ == ACC_MAX && errVal >= 0) |=> accQ == ACC_MAX);  // R7
  AST_ACC_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && accQ == ACC_MIN && errVal <= 0) |=> accQ == ACC_MIN);  // R7
  AST_PREV_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.update |=> prevErrQ == $past(errVal));  // R5
endmodule

// File: rtl/pid_heater_ctrl.sv
module pid_heater_ctrl
  import pid_pkg::*;
#(
  parameter int TEMP_W = 9,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 24,
  localparam int TERM_W = ACC_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sampleEn,
  input  logic [TEMP_W-1:0]        setPoint,
  input  logic [TEMP_W-1:0]        measTemp,
  input  logic [GAIN_W-1:0]        gainP,
  input  logic [GAIN_W-1:0]        gainIs,
  input  logic [GAIN_W-1:0]        gainD,
  output logic [PWR_W-1:0]         powerOut,
  output logic                     powerValid,
  output logic signed [TERM_W-1:0] propTerm,
  output logic signed [TERM_W-1:0] intTerm,
  output logic signed [TERM_W-1:0] derTerm
);
  pid_strobe_t strobe;

  pid_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sampleEn (sampleEn),
    .strobe   (strobe)
  );

  pid_datapath #(
    .TEMP_W (TEMP_W),
    .GAIN_W (GAIN_W),
    .ACC_W  (ACC_W)
  ) uPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .setPoint (setPoint),
    .measTemp (measTemp),
    .gainP    (gainP),
    .gainIs   (gainIs),
    .gainD    (gainD),
    .powerOut (powerOut),
    .propTerm (propTerm),
    .intTerm  (intTerm),
    .derTerm  (derTerm)
  );

  assign powerValid = strobe.publish;
endmodule

// File: tb/tb_pid_heater_ctrl.sv
module tb_pid_heater_ctrl;
  localparam int TEMP_W = 9;
  localparam int GAIN_W = 16;
  localparam int ACC_W  = 24;
  localparam int TERM_W = ACC_W + GAIN_W + 1;
  localparam longint ACC_HI = (longint'(1) << (ACC_W-1)) - 1;
  localparam longint ACC_LO = -(longint'(1) << (ACC_W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleEn = 1'b0;
  logic [TEMP_W-1:0] setPoint = '0, measTemp = '0;
  logic [GAIN_W-1:0] gainP = '0, gainIs = '0, gainD = '0;
  logic [12:0] powerOut;
  logic powerValid;
  logic signed [TERM_W-1:0] propTerm, intTerm, derTerm;

  int nChk = 0, nBad = 0;
  longint mAcc = 0, mPrev = 0, mProp = 0, mInt = 0, mDer = 0, mPow = 0;

  always #2 clk = ~clk;

  pid_heater_ctrl #(.TEMP_W(TEMP_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .setPoint(setPoint),
    .measTemp(measTemp), .gainP(gainP), .gainIs(gainIs), .gainD(gainD),
    .powerOut(powerOut), .powerValid(powerValid), .propTerm(propTerm),
    .intTerm(intTerm), .derTerm(derTerm));

  function automatic longint divTrunc(longint v);
    if (v < 0) return -((-v) >>> 10);
    return v >>> 10;
  endfunction

  function automatic longint clampL(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStep();
    longint e;
    e = longint'(setPoint) - longint'(measTemp);       // R1
    mAcc  = clampL(mAcc + e, ACC_LO, ACC_HI);          // R4, R7
    mProp = longint'(gainP) * e;                        // R3
    mInt  = divTrunc(mAcc * longint'(gainIs));          // R4
    mDer  = longint'(gainD) * (e - mPrev);              // R5
    mPrev = e;
    mPow  = clampL(mProp + mInt + mDer, 0, 5000);       // R6
  endtask

  task automatic checkAll();
    check("R3 prop", longint'(propTerm), mProp);
    check("R4 int", longint'(intTerm), mInt);
    check("R5 der", longint'(derTerm), mDer);
    check("R6 power", longint'(powerOut), mPow);
  endtask

  task automatic doUpdate(int sp, int mt, int p, int is, int d);
    setPoint = TEMP_W'(sp); measTemp = TEMP_W'(mt);
    gainP = GAIN_W'(p); gainIs = GAIN_W'(is); gainD = GAIN_W'(d);
    sampleEn = 1'b1;
    modelStep();
    @(posedge clk); @(negedge clk);
    sampleEn = 1'b0;
    check("R9 valid high", longint'(powerValid), 1);
    checkAll();
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 power zero", longint'(powerOut), 0);
    check("R8 valid zero", longint'(powerValid), 0);
    check("R8 int zero", longint'(intTerm), 0);
    rst_n = 1'b1;
    mAcc = 0; mPrev = 0;
  endtask

  initial begin
    #(4 * 190000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk);
    doReset();

    // R5 first update uses previous error of zero; R1 error at set-point bounds
    doUpdate(250, 240, 10, 0, 7);
    doUpdate(100, 130, 10, 0, 7);

    // R4 negative product truncates toward zero (-5 -> 0, -1030 -> -1)
    doReset();
    doUpdate(20, 25, 0, 1, 0);
    check("R4 trunc small", longint'(intTerm), 0);
    doReset();
    doUpdate(20, 25, 0, 206, 0);
    check("R4 trunc -1030", longint'(intTerm), -1);

    // R6 upper clamp and lower clamp
    doReset();
    doUpdate(250, 0, 1000, 0, 0);
    check("R6 clamp high", longint'(powerOut), 5000);
    doUpdate(0, 250, 1000, 0, 0);
    check("R6 clamp low", longint'(powerOut), 0);

    // R2 outputs hold while inputs move without sampleEn; R9 valid low
    setPoint = 9'd180; measTemp = 9'd20; gainP = 16'd3;
    repeat (3) @(negedge clk);
    check("R9 valid idle", longint'(powerValid), 0);
    check("R2 hold power", longint'(powerOut), mPow);
    check("R2 hold prop", longint'(propTerm), mProp);

    // R7 drive accumulator into lower limit while power pinned at 0
    doReset();
    for (int i = 0; i < 16500; i++) doUpdate(0, 511, 0, 1, 0);
    check("R7 acc low limit", longint'(intTerm), divTrunc(ACC_LO));
    doReset();
    for (int i = 0; i < 16500; i++) doUpdate(511, 0, 0, 1, 0);
    check("R7 acc high limit", longint'(intTerm), divTrunc(ACC_HI));

    // random mix of updates and idle cycles
    doReset();
    for (int i = 0; i < 400; i++) begin
      int idle;
      doUpdate(100 + int'($urandom_range(150)), int'($urandom_range(400)),
               int'($urandom_range(300)), int'($urandom_range(2000)),
               int'($urandom_range(500)));
      idle = int'($urandom_range(2));
      for (int k = 0; k < idle; k++) begin
        @(negedge clk);
        check("R9 valid idle", longint'(powerValid), 0);
        check("R2 hold", longint'(powerOut), mPow);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule